// File: doc/BRIEF.md
# Control Register Space Decoder

This block sits between a processor's load/store path and the control registers of its on-chip peripherals. It takes one 32-bit request at a time (address, write data, access size, read or write). It picks one of ten peripheral register banks from the upper address half and serves the addressed 32-bit slot inside that bank. Every bank has its own offset limit for reads and a separate one for writes. Every slot carries an access class: plain storage, constant, no access, or handler.

Plain and constant slots are kept in a local slot store. Handler slots stand for live peripheral state, such as a running counter. They are forwarded on a side port, and the request completes when that port acknowledges. Two frequently read addresses bypass the decode stage: the exception event register and the timer channel 0 counter. Two reserved bank selects act as write-only sinks. An unmapped bank select answers with zero and raises a one-cycle decode error flag.

Top module: `creg_decoder`

## Requirements
- R1: The bank select is address bits [28:16], the in-bank offset is bits [7:0], and the slot index is offset/4, so offset bits [1:0] are ignored. The mapped selects and their read/write limits are: 0x1FD8 timer (0x2C/0x2C), 0x1F00 cache control (0x44/0x3C), 0x1FA0 DMA (0x40/0x40), 0x1FD0 interrupt control (0x10/0x0C), 0x1FC8 clock (0x3C/0x3C), 0x1F20 break (0x20/0x20), 0x1F80 bus state (0x48/0x48), 0x1FC0 clock generator (0x10/0x10), 0x1FE0 serial A (0x1C/0x1C) and 0x1FE8 serial B (0x24/0x24). The bank index seen on the side port is the position in this list, counting from 0.
- R2: An access to any other select that is not a sink returns read data 0, drops a write, and drives rsp_dec_err high only in its response cycle.
- R3: A read at an offset above the bank's read limit returns 0. A write above the bank's write limit is dropped. Neither raises an error. Examples are cache-control writes at 0x40 and interrupt-control writes at 0x10.
- R4: Plain storage slots reset to 0 and return the last value written.
- R5: Size code 0 means 1 byte and touches only bits [7:0]. Code 1 means 2 bytes and touches only bits [15:0]. Codes 2 and 3 mean 4 bytes. Sub-word reads return the same lanes, zero-extended.
- R6: The no-access slots (cache control 0x14, clock 0x3C) read as 0 and ignore writes.
- R7: The constant slot (clock generator 0x08) reads 0x00000E0A and ignores writes.
- R8: Selects 0x1F90 and 0x1F94 accept writes, discard them, and read as 0, without a decode error.
- R9: The handler slots (timer 0x0C, serial A 0x1C) raise hnd_valid together with write, bank, slot, size and data. These stay stable until hnd_ack. The response follows one cycle after the ack and carries hnd_rdata for reads and 0 for writes.
- R10: A read of exactly 0xFF000028 is answered from the store one cycle after acceptance. Every other non-handler access is answered two cycles after acceptance.
- R11: A read of exactly 0xFFD8000C raises hnd_valid one cycle after acceptance. Other handler accesses, including aliases of that address with different bits [31:29], raise it two cycles after acceptance.
- R12: req_ready is high only when no request is in flight. After reset, req_ready is 1 and rsp_valid and hnd_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Write data |
| req_size | input | 2 | Access size code |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_rdata | output | 32 | Read data |
| rsp_dec_err | output | 1 | Unmapped bank select |
| hnd_valid | output | 1 | Handler request pending |
| hnd_write | output | 1 | Handler request is a write |
| hnd_bank | output | 4 | Bank index of the handler slot |
| hnd_slot | output | 6 | Slot index of the handler slot |
| hnd_wdata | output | 32 | Handler write data |
| hnd_size | output | 2 | Handler access size code |
| hnd_ack | input | 1 | Handler done |
| hnd_rdata | input | 32 | Handler read data |

## Verification
The response latency depends on the path:

- The event-register fast read answers on the first clock edge after acceptance.
- Ordinary accesses answer on the second edge.
- The counter fast read raises the side-port request on the first edge; other handler accesses raise it on the second edge.
- A handler response arrives one edge after the ack.

For every transaction, the bench derives the path from the address alone. It then samples at each falling edge that rsp_valid and hnd_valid stay low until the due cycle and are high exactly then. The bench also holds the ack back for several cycles to confirm that the side-port fields stay stable while waiting.

// File: rtl/creg_pkg.sv
package creg_pkg;

    localparam int NUM_BANKS = 10;
    localparam int SEL_W     = 13;
    localparam int OFF_W     = 8;
    localparam int DATA_W    = 32;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int SLOT_W    = OFF_W - 2;

    localparam logic [SEL_W-1:0]  SINK_SEL_A    = 13'h1F90;
    localparam logic [SEL_W-1:0]  SINK_SEL_B    = 13'h1F94;
    localparam logic [31:0]       FAST_EVT_ADDR = 32'hFF00_0028;
    localparam logic [31:0]       FAST_CNT_ADDR = 32'hFFD8_000C;
    localparam int                EVT_BANK      = 1;
    localparam int                EVT_SLOT      = 10;

    typedef enum logic [1:0] {SC_NONE, SC_CONST, SC_STORE, SC_HANDLER} slot_class_e;
    typedef enum logic [1:0] {ST_IDLE, ST_DECODE, ST_HANDLER} state_e;

    typedef struct packed {
        state_e              state;
        logic                wr;
        logic [SEL_W-1:0]    sel;
        logic [OFF_W-1:0]    off;
        logic [DATA_W-1:0]   wdata;
        logic [1:0]          size;
        logic                rsp_valid;
        logic [DATA_W-1:0]   rsp_rdata;
        logic                rsp_err;
        logic                hnd_valid;
    } ctl_t;

    function automatic logic [SEL_W-1:0] sel_of_bank(int b);
        case (b)
            0: return 13'h1FD8;
            1: return 13'h1F00;
            2: return 13'h1FA0;
            3: return 13'h1FD0;
            4: return 13'h1FC8;
            5: return 13'h1F20;
            6: return 13'h1F80;
            7: return 13'h1FC0;
            8: return 13'h1FE0;
            default: return 13'h1FE8;
        endcase
    endfunction

    function automatic logic [OFF_W-1:0] rd_lim_of(int b);
        case (b)
            0: return 8'h2C;
            1: return 8'h44;
            2: return 8'h40;
            3: return 8'h10;
            4: return 8'h3C;
            5: return 8'h20;
            6: return 8'h48;
            7: return 8'h10;
            8: return 8'h1C;
            default: return 8'h24;
        endcase
    endfunction

    function automatic logic [OFF_W-1:0] wr_lim_of(int b);
        case (b)
            1: return 8'h3C;
            3: return 8'h0C;
            default: return rd_lim_of(b);
        endcase
    endfunction

    function automatic int slot_count(int b);
        return int'(rd_lim_of(b)) / 4 + 1;
    endfunction

    function automatic int base_of(int b);
        int acc = 0;
        for (int i = 0; i < b; i++) acc += slot_count(i);
        return acc;
    endfunction

    localparam int TOTAL_SLOTS = base_of(NUM_BANKS);
    localparam int IDX_W       = $clog2(TOTAL_SLOTS);

    function automatic slot_class_e class_of(int b, int s);
        if ((b == 0 && s == 3) || (b == 8 && s == 7)) return SC_HANDLER;
        if ((b == 1 && s == 5) || (b == 4 && s == 15)) return SC_NONE;
        if (b == 7 && s == 2) return SC_CONST;
        return SC_STORE;
    endfunction

    function automatic logic [DATA_W-1:0] init_value(int flat);
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (flat >= base_of(b) && flat < base_of(b) + slot_count(b)) begin
                if (class_of(b, flat - base_of(b)) == SC_CONST) return 32'h0000_0E0A;
            end
        end
        return '0;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(logic [1:0] size);
        case (size)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/creg_bank_decode.sv
module creg_bank_decode
    import creg_pkg::*;
#(
    parameter int NB     = creg_pkg::NUM_BANKS,
    parameter int SW     = creg_pkg::SEL_W,
    parameter int OW     = creg_pkg::OFF_W,
    parameter int BW     = creg_pkg::BANK_W,
    parameter int IW     = creg_pkg::IDX_W,
    parameter int SLW    = OW - 2
) (
    input  logic [SW-1:0]  sel,
    input  logic [OW-1:0]  off,
    output logic           bank_hit,
    output logic           sink_hit,
    output logic [BW-1:0]  bank_idx,
    output logic [SLW-1:0] slot_idx,
    output logic           rd_in,
    output logic           wr_in,
    output slot_class_e    cls,
    output logic [IW-1:0]  flat_idx
);

    logic [NB-1:0] match;
    logic [OW-1:0] rd_lim, wr_lim;
    logic [IW-1:0] base;

    for (genvar b = 0; b < NB; b++) begin : g_match
        assign match[b] = (sel == sel_of_bank(b));
    end

    assign slot_idx = off[OW-1:2];
    assign sink_hit = (sel == SINK_SEL_A) || (sel == SINK_SEL_B);

    always_comb begin
        bank_hit = 1'b0;
        bank_idx = '0;
        rd_lim   = '0;
        wr_lim   = '0;
        base     = '0;
        cls      = SC_NONE;
        for (int b = 0; b < NB; b++) begin
            if (match[b]) begin
                bank_hit = 1'b1;
                bank_idx = BW'(b);
                rd_lim   = rd_lim_of(b);
                wr_lim   = wr_lim_of(b);
                base     = IW'(base_of(b));
                cls      = class_of(b, int'(slot_idx));
            end
        end
        rd_in    = bank_hit && (off <= rd_lim);
        wr_in    = bank_hit && (off <= wr_lim);
        flat_idx = base + IW'(slot_idx);
    end

endmodule

// File: rtl/creg_slot_store.sv
module creg_slot_store
    import creg_pkg::*;
#(
    parameter int SLOTS = creg_pkg::TOTAL_SLOTS,
    parameter int IW    = creg_pkg::IDX_W,
    parameter int DW    = creg_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [1:0]    wr_size,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    input  logic [1:0]    rd_size,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] slots [SLOTS];
    logic [DW-1:0] cur_word, merged_d, rd_raw, wmask;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [DW-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= init_value(i);
            end else if (wr_en && wr_idx == IW'(i)) begin
                word_q <= merged_d;
            end
        end
        assign slots[i] = word_q;
    end

    always_comb begin
        cur_word = '0;
        rd_raw   = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (wr_idx == IW'(i)) cur_word = slots[i];
            if (rd_idx == IW'(i)) rd_raw   = slots[i];
        end
        wmask    = lane_mask(wr_size);
        merged_d = (cur_word & ~wmask) | (wr_data & wmask);
        rd_data  = rd_raw & lane_mask(rd_size);
    end

endmodule

// File: rtl/creg_decoder.sv
module creg_decoder
    import creg_pkg::*;
#(
    parameter int DW  = creg_pkg::DATA_W,
    parameter int BW  = creg_pkg::BANK_W,
    parameter int SLW = creg_pkg::SLOT_W,
    parameter int IW  = creg_pkg::IDX_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic           req_write,
    input  logic [31:0]    req_addr,
    input  logic [DW-1:0]  req_wdata,
    input  logic [1:0]     req_size,
    output logic           rsp_valid,
    output logic [DW-1:0]  rsp_rdata,
    output logic           rsp_dec_err,
    output logic           hnd_valid,
    output logic           hnd_write,
    output logic [BW-1:0]  hnd_bank,
    output logic [SLW-1:0] hnd_slot,
    output logic [DW-1:0]  hnd_wdata,
    output logic [1:0]     hnd_size,
    input  logic           hnd_ack,
    input  logic [DW-1:0]  hnd_rdata
);

    localparam logic [IW-1:0] EVT_IDX = IW'(base_of(EVT_BANK) + EVT_SLOT);

    ctl_t q, d;

    logic          dec_hit, dec_sink, dec_rd_in, dec_wr_in;
    logic [BW-1:0] dec_bank;
    logic [SLW-1:0] dec_slot;
    slot_class_e   dec_cls;
    logic [IW-1:0] dec_flat;

    logic          st_we;
    logic [IW-1:0] st_ridx;
    logic [1:0]    st_rsize;
    logic [DW-1:0] st_rdata;

    creg_bank_decode i_decode (
        .sel      (q.sel),
        .off      (q.off),
        .bank_hit (dec_hit),
        .sink_hit (dec_sink),
        .bank_idx (dec_bank),
        .slot_idx (dec_slot),
        .rd_in    (dec_rd_in),
        .wr_in    (dec_wr_in),
        .cls      (dec_cls),
        .flat_idx (dec_flat)
    );

    creg_slot_store i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_we),
        .wr_idx  (dec_flat),
        .wr_size (q.size),
        .wr_data (q.wdata),
        .rd_idx  (st_ridx),
        .rd_size (st_rsize),
        .rd_data (st_rdata)
    );

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        d.rsp_err   = 1'b0;
        d.rsp_rdata = '0;
        st_we       = 1'b0;
        st_ridx     = dec_flat;
        st_rsize    = q.size;
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.wr    = req_write;
                    d.sel   = req_addr[28:16];
                    d.off   = req_addr[7:0];
                    d.wdata = req_wdata;
                    d.size  = req_size;
                    if (!req_write && req_addr == FAST_EVT_ADDR) begin
                        // event register: answered straight from the store
                        st_ridx     = EVT_IDX;
                        st_rsize    = req_size;
                        d.rsp_valid = 1'b1;
                        d.rsp_rdata = st_rdata;
                    end else if (!req_write && req_addr == FAST_CNT_ADDR) begin
                        // counter: skip decode, go to the side port at once
                        d.state     = ST_HANDLER;
                        d.hnd_valid = 1'b1;
                    end else begin
                        d.state = ST_DECODE;
                    end
                end
            end
            ST_DECODE: begin
                d.state = ST_IDLE;
                if (!dec_hit) begin
                    d.rsp_valid = 1'b1;
                    d.rsp_err   = !dec_sink;
                end else if (dec_cls == SC_HANDLER && (q.wr ? dec_wr_in : dec_rd_in)) begin
                    d.state     = ST_HANDLER;
                    d.hnd_valid = 1'b1;
                end else begin
                    d.rsp_valid = 1'b1;
                    if (q.wr) begin
                        st_we = dec_wr_in && (dec_cls == SC_STORE);
                    end else if (dec_rd_in && (dec_cls == SC_STORE || dec_cls == SC_CONST)) begin
                        d.rsp_rdata = st_rdata;
                    end
                end
            end
            ST_HANDLER: begin
                if (hnd_ack) begin
                    d.state     = ST_IDLE;
                    d.hnd_valid = 1'b0;
                    d.rsp_valid = 1'b1;
                    d.rsp_rdata = q.wr ? '0 : hnd_rdata;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready   = (q.state == ST_IDLE);
    assign rsp_valid   = q.rsp_valid;
    assign rsp_rdata   = q.rsp_rdata;
    assign rsp_dec_err = q.rsp_err;
    assign hnd_valid   = q.hnd_valid;
    assign hnd_write   = q.wr;
    assign hnd_bank    = dec_bank;
    assign hnd_slot    = dec_slot;
    assign hnd_wdata   = q.wdata;
    assign hnd_size    = q.size;

endmodule

// File: rtl/creg_decoder_chk.sv
module creg_decoder_chk
    import creg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [31:0] req_addr,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        rsp_dec_err,
    input logic        hnd_valid,
    input logic        hnd_write,
    input logic [3:0]  hnd_bank,
    input logic [5:0]  hnd_slot,
    input logic        hnd_ack,
    input logic [31:0] hnd_rdata
);

    assert_err_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_dec_err |-> (rsp_valid && rsp_rdata == 32'h0));

    assert_hnd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hnd_valid && !hnd_ack) |=> (hnd_valid && $stable(hnd_slot) && $stable(hnd_bank) && $stable(hnd_write)));

    assert_hnd_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hnd_valid && hnd_ack && !hnd_write) |=> (rsp_valid && rsp_rdata == $past(hnd_rdata)));

    assert_fast_evt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && req_addr == FAST_EVT_ADDR) |=> (rsp_valid && req_ready));

    assert_slow_path_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_write || (req_addr != FAST_EVT_ADDR && req_addr != FAST_CNT_ADDR)))
        |=> (!rsp_valid && !req_ready && !hnd_valid));

    assert_fast_cnt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && req_addr == FAST_CNT_ADDR) |=> (hnd_valid && !rsp_valid));

    assert_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hnd_valid |-> !req_ready);

endmodule

bind creg_decoder creg_decoder_chk i_creg_decoder_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .rsp_dec_err (rsp_dec_err),
    .hnd_valid   (hnd_valid),
    .hnd_write   (hnd_write),
    .hnd_bank    (hnd_bank),
    .hnd_slot    (hnd_slot),
    .hnd_ack     (hnd_ack),
    .hnd_rdata   (hnd_rdata)
);

// File: tb/test_creg_decoder.sv
`timescale 1ns/1ps
module test_creg_decoder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_size = 2'd2;
    logic        req_ready, rsp_valid, rsp_dec_err;
    logic [31:0] rsp_rdata;
    logic        hnd_valid, hnd_write;
    logic [3:0]  hnd_bank;
    logic [5:0]  hnd_slot;
    logic [31:0] hnd_wdata;
    logic [1:0]  hnd_size;
    logic        hnd_ack = 1'b0;
    logic [31:0] hnd_rdata = '0;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    creg_decoder i_creg_decoder (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_size(req_size),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_dec_err(rsp_dec_err),
        .hnd_valid(hnd_valid), .hnd_write(hnd_write), .hnd_bank(hnd_bank),
        .hnd_slot(hnd_slot), .hnd_wdata(hnd_wdata), .hnd_size(hnd_size),
        .hnd_ack(hnd_ack), .hnd_rdata(hnd_rdata)
    );

    // reference model, built from the requirement text
    logic [12:0] sels   [10] = '{13'h1FD8, 13'h1F00, 13'h1FA0, 13'h1FD0, 13'h1FC8,
                                 13'h1F20, 13'h1F80, 13'h1FC0, 13'h1FE0, 13'h1FE8};
    int          rdlim  [10] = '{'h2C, 'h44, 'h40, 'h10, 'h3C, 'h20, 'h48, 'h10, 'h1C, 'h24};
    int          wrlim  [10] = '{'h2C, 'h3C, 'h40, 'h0C, 'h3C, 'h20, 'h48, 'h10, 'h1C, 'h24};
    logic [31:0] mdl [int];

    function automatic int bank_of(logic [12:0] s);
        for (int i = 0; i < 10; i++) if (sels[i] == s) return i;
        return -1;
    endfunction

    // 0 none, 1 constant, 2 storage, 3 handler
    function automatic int kind_of(int b, int off);
        if ((b == 0 && off == 'h0C) || (b == 8 && off == 'h1C)) return 3;
        if ((b == 1 && off == 'h14) || (b == 4 && off == 'h3C)) return 0;
        if (b == 7 && off == 'h08) return 1;
        return 2;
    endfunction

    function automatic logic [31:0] msk(logic [1:0] sz);
        return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] mval(int b, int off);
        int key = b * 256 + off;
        if (kind_of(b, off) == 1) return 32'h0000_0E0A;
        if (mdl.exists(key)) return mdl[key];
        return 32'h0;
    endfunction

    task automatic chk(logic [31:0] act, logic [31:0] exp, string rq, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic txn(bit wr, logic [31:0] addr, logic [31:0] data, logic [1:0] sz,
                       int ack_dly, logic [31:0] hval, string rq);
        int b, off, al, kind;
        bit fast_evt, fast_cnt, is_hnd, err;
        logic [31:0] exp;
        b        = bank_of(addr[28:16]);
        off      = int'(addr[7:0]);
        al       = off & 'hFC;
        fast_evt = !wr && addr == 32'hFF00_0028;
        fast_cnt = !wr && addr == 32'hFFD8_000C;
        kind     = (b >= 0) ? kind_of(b, al) : 0;
        is_hnd   = fast_cnt || (b >= 0 && kind == 3 && off <= (wr ? wrlim[b] : rdlim[b]));
        err      = (b < 0) && addr[28:16] != 13'h1F90 && addr[28:16] != 13'h1F94;
        exp      = 32'h0;
        if (!wr && b >= 0 && off <= rdlim[b] && (kind == 1 || kind == 2))
            exp = mval(b, al) & msk(sz);
        chk({31'b0, req_ready}, 32'd1, "R12", "ready before request");
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data; req_size = sz;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        if (fast_evt) begin
            chk({31'b0, rsp_valid}, 32'd1, "R10", "fast event response cycle");
            chk(rsp_rdata, exp, rq, "fast event data");
            chk({31'b0, rsp_dec_err}, 32'd0, rq, "fast event err");
        end else if (is_hnd) begin
            if (!fast_cnt) begin
                chk({30'b0, hnd_valid, rsp_valid}, 32'd0, "R11", "handler not yet raised");
                @(negedge clk);
            end
            chk({31'b0, hnd_valid}, 32'd1, fast_cnt ? "R11" : "R9", "handler raised");
            chk({hnd_write, 1'b0, hnd_size, hnd_bank, 2'b0, hnd_slot}, {wr, 1'b0, sz, 4'(b), 2'b0, 6'(al / 4)},
                "R9", "handler fields");
            chk(hnd_wdata, data, "R9", "handler wdata");
            for (int k = 0; k < ack_dly; k++) begin
                @(negedge clk);
                chk({30'b0, hnd_valid, rsp_valid}, 32'd2, "R9", "handler waiting");
                chk({26'b0, hnd_slot}, 32'(al / 4), "R9", "slot held");
            end
            hnd_ack = 1'b1; hnd_rdata = hval;
            @(negedge clk);
            hnd_ack = 1'b0;
            chk({30'b0, hnd_valid, rsp_valid}, 32'd1, "R9", "handler response cycle");
            chk(rsp_rdata, wr ? 32'h0 : hval, "R9", "handler data");
        end else begin
            chk({30'b0, rsp_valid, req_ready}, 32'd0, "R10", "no early response");
            @(negedge clk);
            chk({31'b0, rsp_valid}, 32'd1, "R10", "response cycle");
            chk(rsp_rdata, exp, rq, "read data");
            chk({31'b0, rsp_dec_err}, {31'b0, err}, rq, "decode error");
        end
        if (wr && b >= 0 && off <= wrlim[b] && kind == 2)
            mdl[b * 256 + al] = (mval(b, al) & ~msk(sz)) | (data & msk(sz));
    endtask

    function automatic logic [31:0] adr(logic [12:0] s, logic [7:0] o);
        return {3'b111, s, 8'h00, o};
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        int unsigned seed = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk({29'b0, req_ready, rsp_valid, hnd_valid}, 32'd4, "R12", "reset state");

        // R4 / R5 storage and lanes
        txn(1, adr(13'h1FA0, 8'h10), 32'h1234_5678, 2, 0, 0, "R4");
        txn(0, adr(13'h1FA0, 8'h10), 0, 2, 0, 0, "R4");
        txn(0, adr(13'h1FA0, 8'h10), 0, 0, 0, 0, "R5");
        txn(0, adr(13'h1FA0, 8'h12), 0, 1, 0, 0, "R5");
        txn(1, adr(13'h1FA0, 8'h10), 32'hFFFF_FFAB, 0, 0, 0, "R5");
        txn(0, adr(13'h1FA0, 8'h11), 0, 3, 0, 0, "R1");
        txn(1, adr(13'h1FA0, 8'h10), 32'hAAAA_CDEF, 1, 0, 0, "R5");
        txn(0, adr(13'h1FA0, 8'h10), 0, 2, 0, 0, "R5");
        txn(0, adr(13'h1F20, 8'h04), 0, 2, 0, 0, "R4");

        // R3 limits
        txn(1, adr(13'h1FA0, 8'h40), 32'h0BAD_F00D, 2, 0, 0, "R3");
        txn(0, adr(13'h1FA0, 8'h40), 0, 2, 0, 0, "R3");
        txn(1, adr(13'h1FA0, 8'h44), 32'h5555_5555, 2, 0, 0, "R3");
        txn(0, adr(13'h1FA0, 8'h44), 0, 2, 0, 0, "R3");
        txn(1, adr(13'h1F00, 8'h40), 32'h7777_7777, 2, 0, 0, "R3");
        txn(0, adr(13'h1F00, 8'h40), 0, 2, 0, 0, "R3");
        txn(1, adr(13'h1F00, 8'h3C), 32'h3C3C_3C3C, 2, 0, 0, "R3");
        txn(0, adr(13'h1F00, 8'h3C), 0, 2, 0, 0, "R3");
        txn(1, adr(13'h1FD0, 8'h10), 32'h1010_1010, 2, 0, 0, "R3");
        txn(0, adr(13'h1FD0, 8'h10), 0, 2, 0, 0, "R3");
        txn(1, adr(13'h1FD0, 8'h0C), 32'h0C0C_0C0C, 2, 0, 0, "R3");
        txn(0, adr(13'h1FD0, 8'h0C), 0, 2, 0, 0, "R3");

        // R2 unmapped, R8 sinks
        txn(0, adr(13'h1F44, 8'h00), 0, 2, 0, 0, "R2");
        txn(1, adr(13'h1F44, 8'h04), 32'hDEAD_BEEF, 2, 0, 0, "R2");
        txn(1, adr(13'h1F90, 8'h00), 32'h1111_2222, 2, 0, 0, "R8");
        txn(0, adr(13'h1F90, 8'h00), 0, 2, 0, 0, "R8");
        txn(1, adr(13'h1F94, 8'h08), 32'h3333_4444, 2, 0, 0, "R8");
        txn(0, adr(13'h1F94, 8'h08), 0, 2, 0, 0, "R8");

        // R6 no access, R7 constant
        txn(1, adr(13'h1F00, 8'h14), 32'hFFFF_FFFF, 2, 0, 0, "R6");
        txn(0, adr(13'h1F00, 8'h14), 0, 2, 0, 0, "R6");
        txn(1, adr(13'h1FC8, 8'h3C), 32'h1234_0000, 2, 0, 0, "R6");
        txn(0, adr(13'h1FC8, 8'h3C), 0, 2, 0, 0, "R6");
        txn(0, adr(13'h1FC0, 8'h08), 0, 2, 0, 0, "R7");
        txn(1, adr(13'h1FC0, 8'h08), 32'h0000_0000, 2, 0, 0, "R7");
        txn(0, adr(13'h1FC0, 8'h08), 0, 2, 0, 0, "R7");
        txn(0, adr(13'h1FC0, 8'h08), 0, 0, 0, 0, "R7");

        // R9 / R11 handler slots
        txn(0, 32'hFFD8_000C, 0, 2, 3, 32'hCAFE_0001, "R11");
        txn(0, 32'h1FD8_000C, 0, 2, 0, 32'hCAFE_0002, "R11");
        txn(1, 32'hFFD8_000C, 32'h0000_0099, 2, 1, 32'hFFFF_FFFF, "R9");
        txn(0, adr(13'h1FE0, 8'h1C), 0, 0, 2, 32'h0000_0042, "R9");

        // R10 fast event read
        txn(1, 32'hFF00_0028, 32'h0000_0140, 2, 0, 0, "R10");
        txn(0, 32'hFF00_0028, 0, 2, 0, 0, "R10");
        txn(0, 32'hFF00_0028, 0, 0, 0, 0, "R10");
        txn(0, 32'h1F00_0028, 0, 2, 0, 0, "R10");

        // mixed traffic against the model
        for (int n = 0; n < 60; n++) begin
            logic [12:0] s;
            seed = seed * 1103515245 + 12345;
            s = ((seed >> 4) % 12 == 11) ? 13'h1F44 : sels[(seed >> 4) % 10];
            txn(seed[20], adr(s, 8'((seed >> 8) % 'h50)), seed ^ 32'h5A5A_A5A5,
                2'(seed >> 24), int'((seed >> 28) % 3), seed, "R4");
        end

        done = 1;
        finish_run();
    end

endmodule